// File: doc/BRIEF.md
# Response Error Status Router

This block sits on the receive side of a packetized memory-link controller, after header decoding. Each response arrives as a decoded header (packet kind, error-status value, cube identifier, sequence tag) plus a payload word, under a valid/ready handshake. The router sends each response one of three ways. It can forward it to the application unchanged. It can forward it with an error sideband raised. Or it can keep it off the data path and queue its error status and cube identifier for software.

Software sees the oldest queued error through a register-style read port. A pop strobe removes that entry. A small interrupt-status register records two events: sequence tags that arrive out of order, and error packets lost because the queue was full. Software clears these bits by writing ones. A masked OR of the status bits drives a single interrupt line.

Top module: `rsp_err_router`

## Requirements
- R1: A response whose error status is zero is forwarded with kind and payload unchanged and `out_err` low. This holds for every kind, including the error kind (kind encoding: 0 read, 1 write, 2 mode, 3 error).
- R2: A read, write or mode response with a nonzero error status is forwarded normally, with `out_err` high for that beat.
- R3: An error-kind response with a nonzero status never appears on the output stream and is always accepted (`in_ready` high), whatever the state of the output.
- R4: Each diverted response pushes its status and cube identifier into a queue of `FIFO_DEPTH` entries. `errq_rdata` shows the oldest entry as bit 10 = valid, bits 9:7 = cube, bits 6:0 = status. The whole word reads zero when the queue is empty.
- R5: A one-cycle `errq_pop` pulse removes the head entry, so entries leave in arrival order. A pop on an empty queue has no effect.
- R6: A diverted response that finds the queue full is dropped and sets the overflow bit, `irq_status[1]`. The queued entries stay unchanged.
- R7: The expected sequence tag starts at 0 after reset and advances modulo 8 with each accepted response. A mismatch sets `irq_status[0]`, and the expected tag then follows on from the received one.
- R8: Writing with `irq_wr_en` clears every status bit whose `irq_wr_data` bit is one. A bit being set in the same cycle stays set.
- R9: `irq` is high exactly when some status bit is set and its `irq_enable` bit is one.
- R10: While `out_valid` is high and `out_ready` low, the output beat holds steady and forwardable responses are stalled (`in_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded response present |
| in_ready | output | 1 | Response accepted this cycle when valid |
| in_kind | input | 2 | Response kind (0 read, 1 write, 2 mode, 3 error) |
| in_errstat | input | 7 | Error-status field |
| in_cube | input | 3 | Cube identifier |
| in_seq | input | 3 | Sequence tag |
| in_payload | input | 32 | Response data word |
| out_valid | output | 1 | Forwarded response present |
| out_ready | input | 1 | Application accepts the beat |
| out_kind | output | 2 | Forwarded response kind |
| out_payload | output | 32 | Forwarded data word |
| out_err | output | 1 | Forwarded response carried a nonzero status |
| errq_pop | input | 1 | Remove head of the error queue |
| errq_rdata | output | 11 | Head of the error queue with its valid bit |
| irq_wr_en | input | 1 | Write-one-to-clear strobe for status |
| irq_wr_data | input | 2 | Bits to clear |
| irq_enable | input | 2 | Interrupt mask |
| irq_status | output | 2 | Sticky status: bit 0 sequence error, bit 1 overflow |
| irq | output | 1 | Interrupt line |

## Verification
The bench sends an error-kind response with zero status. A router that decoded only the kind would divert it instead of forwarding it. It fills the queue and pushes one more entry. A design that overwrote the head or advanced the write pointer would then pop out a corrupted order. A design that lost the overflow indication would show a clear status bit. Out-of-order tags are followed by an in-order one: a design that did not resynchronize would keep flagging. A clear and a set aimed at the same bit in one cycle catch a design where the clear wins. With the output stalled, the bench checks that an error-kind packet still gets in while a read response waits.

// File: rtl/rsp_err_pkg.sv
package rsp_err_pkg;
   typedef enum logic [1:0] {
      KIND_RD   = 2'd0,
      KIND_WR   = 2'd1,
      KIND_MODE = 2'd2,
      KIND_ERR  = 2'd3
   } rsp_kind_e;

   localparam int STAT_SEQ_BIT = 0;
   localparam int STAT_OVF_BIT = 1;
   localparam int STAT_W       = 2;
endpackage

// File: rtl/rsp_seq_tracker.sv
module rsp_seq_tracker #(
   parameter int SEQ_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_en,
   input  logic [SEQ_W-1:0] rx_seq,
   output logic             mismatch
);
   logic [SEQ_W-1:0] expect_q;

   if (SEQ_W < 1) begin : g_bad_seq
      $error("rsp_seq_tracker: SEQ_W must be at least 1");
   end

   assign mismatch = chk_en && (rx_seq != expect_q);

   // Following on from the received tag covers both the in-order
   // advance and the resynchronisation after a gap.
   always_ff @(posedge clk) begin
      if (!rst_n)
         expect_q <= '0;
      else if (chk_en)
         expect_q <= rx_seq + 1'b1;
   end
endmodule

// File: rtl/rsp_err_fifo.sv
module rsp_err_fifo #(
   parameter int ENTRY_W = 10,
   parameter int DEPTH   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head,
   output logic               full,
   output logic               empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << PW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("rsp_err_fifo: DEPTH must be at least 2");
   end
   if (ENTRY_W < 1) begin : g_bad_width
      $error("rsp_err_fifo: ENTRY_W must be at least 1");
   end

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PW-1:0]      wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]      count;
   logic               do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push)
         mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rsp_irq_regs.sv
module rsp_irq_regs #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_en,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] enable,
   output logic [N-1:0] status,
   output logic         irq
);
   logic [N-1:0] status_q;
   logic [N-1:0] clr_eff;

   assign clr_eff = clr_en ? clr_mask : '0;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            status_q[i] <= 1'b0;
         else if (set[i])
            status_q[i] <= 1'b1;
         else if (clr_eff[i])
            status_q[i] <= 1'b0;
      end
   end

   assign status = status_q;
   assign irq    = |(status_q & enable);
endmodule

// File: rtl/rsp_err_router.sv
module rsp_err_router
   import rsp_err_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ESTAT_W    = 7,
   parameter int CUBE_W     = 3,
   parameter int SEQ_W      = 3,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [1:0]                   in_kind,
   input  logic [ESTAT_W-1:0]           in_errstat,
   input  logic [CUBE_W-1:0]            in_cube,
   input  logic [SEQ_W-1:0]             in_seq,
   input  logic [DATA_W-1:0]            in_payload,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [1:0]                   out_kind,
   output logic [DATA_W-1:0]            out_payload,
   output logic                         out_err,
   input  logic                         errq_pop,
   output logic [ESTAT_W+CUBE_W:0]      errq_rdata,
   input  logic                         irq_wr_en,
   input  logic [STAT_W-1:0]            irq_wr_data,
   input  logic [STAT_W-1:0]            irq_enable,
   output logic [STAT_W-1:0]            irq_status,
   output logic                         irq
);
   localparam int ENTRY_W = ESTAT_W + CUBE_W;

   if (DATA_W < 1) begin : g_bad_data
      $error("rsp_err_router: DATA_W must be at least 1");
   end
   if (ESTAT_W < 1 || CUBE_W < 1) begin : g_bad_fields
      $error("rsp_err_router: field widths must be at least 1");
   end

   logic               divert, fwd_space, accept;
   logic               q_full, q_empty, seq_bad;
   logic [ENTRY_W-1:0] q_head;
   logic [STAT_W-1:0]  stat_set;

   logic               ov_q, oerr_q;
   logic [1:0]         okind_q;
   logic [DATA_W-1:0]  opay_q;

   assign divert    = (in_kind == KIND_ERR) && (in_errstat != '0);
   assign fwd_space = !ov_q || out_ready;
   assign in_ready  = divert ? 1'b1 : fwd_space;
   assign accept    = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_q    <= 1'b0;
         oerr_q  <= 1'b0;
         okind_q <= '0;
         opay_q  <= '0;
      end else if (accept && !divert) begin
         ov_q    <= 1'b1;
         oerr_q  <= (in_errstat != '0);
         okind_q <= in_kind;
         opay_q  <= in_payload;
      end else if (out_ready) begin
         ov_q    <= 1'b0;
      end
   end

   assign out_valid   = ov_q;
   assign out_err     = oerr_q;
   assign out_kind    = okind_q;
   assign out_payload = opay_q;

   rsp_err_fifo #(
      .ENTRY_W (ENTRY_W),
      .DEPTH   (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept && divert),
      .wdata ({in_cube, in_errstat}),
      .pop   (errq_pop),
      .head  (q_head),
      .full  (q_full),
      .empty (q_empty)
   );

   assign errq_rdata = q_empty ? '0 : {1'b1, q_head};

   rsp_seq_tracker #(
      .SEQ_W (SEQ_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .chk_en   (accept),
      .rx_seq   (in_seq),
      .mismatch (seq_bad)
   );

   always_comb begin
      stat_set               = '0;
      stat_set[STAT_SEQ_BIT] = seq_bad;
      stat_set[STAT_OVF_BIT] = accept && divert && q_full;
   end

   rsp_irq_regs #(
      .N (STAT_W)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (stat_set),
      .clr_en   (irq_wr_en),
      .clr_mask (irq_wr_data),
      .enable   (irq_enable),
      .status   (irq_status),
      .irq      (irq)
   );
endmodule

// File: rtl/rsp_err_router_chk.sv
module rsp_err_router_chk
   import rsp_err_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ESTAT_W    = 7,
   parameter int CUBE_W     = 3,
   parameter int SEQ_W      = 3,
   parameter int FIFO_DEPTH = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [1:0]              out_kind,
   input logic [DATA_W-1:0]       out_payload,
   input logic                    out_err,
   input logic [ESTAT_W+CUBE_W:0] errq_rdata,
   input logic                    irq_wr_en,
   input logic [STAT_W-1:0]       irq_wr_data,
   input logic [STAT_W-1:0]       irq_status,
   input logic                    irq
);
   // R3
   err_kind_never_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == KIND_ERR) |-> !out_err);

   // R10
   stall_holds_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_payload) && $stable(out_err)));

   // R4
   empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !errq_rdata[ESTAT_W+CUBE_W] |-> (errq_rdata == '0));

   // R6
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[STAT_OVF_BIT] && !(irq_wr_en && irq_wr_data[STAT_OVF_BIT]))
      |=> irq_status[STAT_OVF_BIT]);

   // R9
   quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status == '0) |-> !irq);
endmodule

bind rsp_err_router rsp_err_router_chk #(
   .DATA_W     (DATA_W),
   .ESTAT_W    (ESTAT_W),
   .CUBE_W     (CUBE_W),
   .SEQ_W      (SEQ_W),
   .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (.*);

// File: tb/tb_rsp_err_router.sv
`timescale 1ns/1ps
module tb_rsp_err_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_kind = 2'd0;
   logic [6:0]  in_errstat = '0;
   logic [2:0]  in_cube = '0;
   logic [2:0]  in_seq = '0;
   logic [31:0] in_payload = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [1:0]  out_kind;
   logic [31:0] out_payload;
   logic        out_err;
   logic        errq_pop = 1'b0;
   logic [10:0] errq_rdata;
   logic        irq_wr_en = 1'b0;
   logic [1:0]  irq_wr_data = '0;
   logic [1:0]  irq_enable = '0;
   logic [1:0]  irq_status;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [2:0] nseq = '0;

   always #2.5 clk = ~clk;

   rsp_err_router dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FIFO FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ent(input logic [2:0] c, input logic [6:0] s);
      return {21'd0, 1'b1, c, s};
   endfunction

   // Drive one beat at a falling edge, leave it through one rising edge.
   task automatic send(input logic [1:0] k, input logic [6:0] s, input logic [2:0] c,
                       input logic [2:0] sq, input logic [31:0] p);
      in_valid = 1'b1; in_kind = k; in_errstat = s; in_cube = c; in_seq = sq; in_payload = p;
      @(negedge clk);
      in_valid = 1'b0;
      nseq = sq + 3'd1;
   endtask

   task automatic pop_one();
      errq_pop = 1'b1;
      @(negedge clk);
      errq_pop = 1'b0;
   endtask

   task automatic clear_status(input logic [1:0] m);
      irq_wr_en = 1'b1; irq_wr_data = m;
      @(negedge clk);
      irq_wr_en = 1'b0; irq_wr_data = '0;
   endtask

   task automatic t_reset();
      chk("R1 reset out_valid", out_valid, 0);
      chk("R4 reset queue", errq_rdata, 0);
      chk("R7 reset status", irq_status, 0);
      chk("R9 reset irq", irq, 0);
   endtask

   task automatic t_clean();
      send(2'd0, 7'd0, 3'd0, nseq, 32'hA5A5_0001);
      chk("R1 valid", out_valid, 1);
      chk("R1 err low", out_err, 0);
      chk("R1 payload", out_payload, 32'hA5A5_0001);
      chk("R1 kind", out_kind, 0);
      send(2'd3, 7'd0, 3'd4, nseq, 32'h0000_E000);
      chk("R1 error kind zero status forwarded", {out_valid, out_kind}, 3'b111);
      chk("R1 error kind zero status err", out_err, 0);
      chk("R1 nothing queued", errq_rdata, 0);
   endtask

   task automatic t_flag();
      send(2'd1, 7'd5, 3'd0, nseq, 32'h1111);
      chk("R2 write flagged", {out_valid, out_err}, 2'b11);
      send(2'd2, 7'h7F, 3'd0, nseq, 32'h2222);
      chk("R2 mode flagged", {out_valid, out_err}, 2'b11);
      chk("R2 mode payload", out_payload, 32'h2222);
      send(2'd0, 7'd1, 3'd0, nseq, 32'h3333);
      chk("R2 read flagged", {out_valid, out_err, out_kind}, 4'b1100);
   endtask

   task automatic t_divert_fill();
      send(2'd3, 7'h12, 3'd5, nseq, 32'hDEAD);
      chk("R3 not forwarded", out_valid, 0);
      chk("R4 head entry", errq_rdata, ent(3'd5, 7'h12));
      send(2'd3, 7'h21, 3'd1, nseq, 32'h0);
      send(2'd3, 7'h33, 3'd2, nseq, 32'h0);
      send(2'd3, 7'h44, 3'd7, nseq, 32'h0);
      chk("R4 head unchanged while filling", errq_rdata, ent(3'd5, 7'h12));
      chk("R6 no overflow yet", irq_status[1], 0);
      send(2'd3, 7'h55, 3'd6, nseq, 32'h0);
      chk("R6 overflow set", irq_status[1], 1);
      chk("R3 still not forwarded", out_valid, 0);
      pop_one();
      chk("R5 second entry", errq_rdata, ent(3'd1, 7'h21));
      pop_one();
      chk("R5 third entry", errq_rdata, ent(3'd2, 7'h33));
      pop_one();
      chk("R6 dropped entry absent", errq_rdata, ent(3'd7, 7'h44));
      pop_one();
      chk("R5 drained", errq_rdata, 0);
      pop_one();
      chk("R5 pop on empty", errq_rdata, 0);
      chk("R7 in-order tags no error", irq_status[0], 0);
   endtask

   task automatic t_seq_irq();
      clear_status(2'b11);
      chk("R8 cleared", irq_status, 0);
      irq_enable = 2'b00;
      send(2'd0, 7'd0, 3'd0, nseq + 3'd3, 32'h44);
      chk("R7 mismatch flagged", irq_status, 2'b01);
      chk("R9 masked irq", irq, 0);
      irq_enable = 2'b10;
      #1 chk("R9 other bit enabled", irq, 0);
      irq_enable = 2'b01;
      #1 chk("R9 enabled irq", irq, 1);
      clear_status(2'b01);
      chk("R8 w1c", irq_status, 0);
      send(2'd0, 7'd0, 3'd0, nseq, 32'h45);
      chk("R7 resync", irq_status, 0);
      send(2'd1, 7'd0, 3'd0, 3'd7, 32'h46);
      clear_status(2'b01);
      send(2'd1, 7'd0, 3'd0, 3'd0, 32'h47);
      chk("R7 wrap 7 to 0", irq_status, 0);
      // Same-cycle set and clear on bit 0.
      irq_wr_en = 1'b1; irq_wr_data = 2'b01;
      send(2'd0, 7'd0, 3'd0, nseq + 3'd2, 32'h48);
      irq_wr_en = 1'b0; irq_wr_data = '0;
      chk("R8 set wins", irq_status[0], 1);
      clear_status(2'b11);
   endtask

   task automatic t_backpressure();
      out_ready = 1'b0;
      send(2'd0, 7'd0, 3'd0, nseq, 32'hBEEF_0001);
      chk("R10 held beat", out_payload, 32'hBEEF_0001);
      in_valid = 1'b1; in_kind = 2'd3; in_errstat = 7'd3; in_cube = 3'd2; in_seq = nseq;
      #1 chk("R3 accepted under stall", in_ready, 1);
      @(negedge clk);
      nseq = nseq + 3'd1;
      chk("R4 queued under stall", errq_rdata, ent(3'd2, 7'd3));
      in_kind = 2'd0; in_errstat = '0; in_seq = nseq; in_payload = 32'hBEEF_0002;
      #1 chk("R10 forwardable stalled", in_ready, 0);
      @(negedge clk);
      chk("R10 beat stable", out_payload, 32'hBEEF_0001);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      nseq = nseq + 3'd1;
      chk("R10 next beat after release", out_payload, 32'hBEEF_0002);
      chk("R7 no false mismatch", irq_status, 0);
      pop_one();
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_flag();
      t_divert_fill();
      t_seq_irq();
      t_backpressure();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule